// File: doc/BRIEF.md
# Coprocessor Instruction Queue Tracker

This block sits inside a numeric coprocessor that shares a bus with a host CPU. The host prefetches instruction bytes into its own queue. The coprocessor sees those bytes on the data bus but cannot tell on its own when the host uses them. The tracker keeps a shadow copy of the host queue. Every completed fetch pushes the fetched bytes into the copy. The host drives a 2-bit queue status code on each clock, and that code decides when bytes leave the copy and when the copy is flushed.

When the host takes the first byte of an opcode and that byte carries the escape pattern, the tracker arms. The next byte the host takes becomes the operand-descriptor byte. The two bytes together are offered to the execution side as one coprocessor instruction on a valid/ready output. A strap sampled during reset tells the tracker whether the host has a 16-bit bus or an 8-bit bus. That choice sets both the shadow depth and the number of bytes each fetch pushes.

Top module: `esc_queue_tracker`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `ins_valid` and `overrun` are 0 and the shadow queue is empty. Popping from it after reset yields no instruction.
- R2: If `wide_strap` is 1 during reset, the depth is 6 bytes. Each fetch pushes `fetch_data[7:0]` first and then `fetch_data[15:8]`.
- R3: If `wide_strap` is 0 during reset, the depth is 4 bytes. Each fetch pushes only `fetch_data[7:0]`.
- R4: A fetch whose byte count would take the queue past its depth is ignored as a whole. The check uses the occupancy at the start of the cycle, before any pop in that cycle.
- R5: Status code 00 leaves the queue and the capture state unchanged, so idle cycles may sit between the two bytes of an instruction.
- R6: Status code 01 pops the oldest byte as a first opcode byte. The tracker arms only when bits 7..3 of that byte equal 11011. Any other first byte disarms it.
- R7: Status code 11 pops the oldest byte. If the tracker is armed, the instruction {first byte, this byte} appears on `ins_op`/`ins_modrm` with `ins_valid` high from the next cycle, and the tracker disarms. If it is not armed, the byte is discarded.
- R8: Status code 10 empties the queue and disarms the tracker. A fetch in the same cycle is dropped.
- R9: While `ins_valid` is high and `ins_ready` is low, the instruction fields hold steady. A clock edge with both signals high takes the instruction, and `ins_valid` falls unless a new instruction completes in that same cycle.
- R10: A status code of 01 while an instruction is held (valid and not ready) sets `overrun`. Only reset clears it. An instruction that completes while the output is held is dropped.
- R11: A pop code (01 or 11) on an empty queue pops nothing. Code 01 still disarms the tracker.
- R12: The strap is sampled only during reset. Changing it afterwards has no effect on the depth or on the push width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wide_strap | input | 1 | Host bus width strap, 1 = 16-bit host, sampled during reset |
| fetch_valid | input | 1 | A host instruction fetch completes this cycle |
| fetch_data | input | 16 | Bus data of that fetch |
| qstat | input | 2 | Host queue status: 00 idle, 01 first byte, 10 flush, 11 next byte |
| ins_valid | output | 1 | Captured instruction is available |
| ins_ready | input | 1 | Consumer accepts the instruction |
| ins_op | output | 8 | Escape opcode byte |
| ins_modrm | output | 8 | Byte that followed the escape opcode |
| overrun | output | 1 | Sticky: a first byte arrived while an instruction was held |

## Verification
The bound checker watches several invariants on every cycle. It checks that occupancy never exceeds the selected depth and that idle and flush codes have their effect on occupancy. It also checks that only escape opcodes reach the output, that a held instruction stays stable, and that the overrun flag rises and then stays set. Other behaviours can only be shown by the bench's scenarios, because they depend on which bytes the host eventually pops. These include byte order within a word, dropping a fetch that does not fit, discarding a half-captured instruction on flush, losing an instruction that completes while the output is held, and ignoring the strap after reset.

// File: rtl/esc_queue_tracker.sv
module esc_queue_tracker #(
  parameter int          DEPTH_WIDE   = 6,
  parameter int          DEPTH_NARROW = 4,
  parameter int          ESC_BITS     = 5,
  parameter logic [4:0]  ESC_PATTERN  = 5'b11011
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wide_strap,
  input  logic        fetch_valid,
  input  logic [15:0] fetch_data,
  input  logic [1:0]  qstat,
  output logic        ins_valid,
  input  logic        ins_ready,
  output logic [7:0]  ins_op,
  output logic [7:0]  ins_modrm,
  output logic        overrun
);

  localparam int CW = $clog2(DEPTH_WIDE + 1);
  localparam logic [1:0] QS_IDLE  = 2'b00;
  localparam logic [1:0] QS_FIRST = 2'b01;
  localparam logic [1:0] QS_FLUSH = 2'b10;
  localparam logic [1:0] QS_NEXT  = 2'b11;

  logic          wide_q;
  logic [7:0]    slot_q [DEPTH_WIDE];
  logic [7:0]    slot_d [DEPTH_WIDE];
  logic [CW-1:0] cnt_q, cnt_d, base;
  logic          arm_q;
  logic [7:0]    op_q;

  logic [CW:0]   depth, nbytes;
  logic [7:0]    head;
  logic          is_first, is_next, is_flush, is_idle;
  logic          pop, fits, do_push, esc_hit, held, complete;

  assign depth    = wide_q ? (CW+1)'(DEPTH_WIDE) : (CW+1)'(DEPTH_NARROW);
  assign nbytes   = wide_q ? (CW+1)'(2) : (CW+1)'(1);
  assign head     = slot_q[0];
  assign is_idle  = qstat == QS_IDLE;
  assign is_first = qstat == QS_FIRST;
  assign is_next  = qstat == QS_NEXT;
  assign is_flush = qstat == QS_FLUSH;
  assign pop      = (is_first || is_next) && cnt_q != '0;
  assign fits     = ({1'b0, cnt_q} + nbytes) <= depth;
  assign do_push  = fetch_valid && fits && !is_flush;
  assign esc_hit  = head[7 -: ESC_BITS] == ESC_PATTERN[ESC_BITS-1:0];
  assign held     = ins_valid && !ins_ready;
  assign complete = is_next && pop && arm_q;

  always_comb begin
    slot_d = slot_q;
    base   = cnt_q;
    if (pop) begin
      for (int i = 0; i < DEPTH_WIDE - 1; i++) slot_d[i] = slot_q[i+1];
      base = cnt_q - CW'(1);
    end
    if (do_push) begin
      for (int i = 0; i < DEPTH_WIDE; i++) begin
        if (CW'(i) == base) slot_d[i] = fetch_data[7:0];
        if (wide_q && CW'(i) == base + CW'(1)) slot_d[i] = fetch_data[15:8];
      end
    end
    if (is_flush)     cnt_d = '0;
    else if (do_push) cnt_d = base + nbytes[CW-1:0];
    else              cnt_d = base;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wide_q <= wide_strap;
      cnt_q  <= '0;
      for (int i = 0; i < DEPTH_WIDE; i++) slot_q[i] <= '0;
    end else begin
      cnt_q  <= cnt_d;
      slot_q <= slot_d;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      arm_q <= 1'b0;
      op_q  <= '0;
    end else if (is_flush) begin
      arm_q <= 1'b0;
    end else if (is_first) begin
      arm_q <= pop && esc_hit;
      if (pop) op_q <= head;
    end else if (complete) begin
      arm_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ins_valid <= 1'b0;
      ins_op    <= '0;
      ins_modrm <= '0;
      overrun   <= 1'b0;
    end else begin
      if (is_first && held) overrun <= 1'b1;
      if (complete && !held) begin
        ins_valid <= 1'b1;
        ins_op    <= op_q;
        ins_modrm <= head;
      end else if (ins_valid && ins_ready) begin
        ins_valid <= 1'b0;
      end
    end
  end

  logic unused_idle;
  assign unused_idle = is_idle;

endmodule

// File: rtl/esc_queue_tracker_chk.sv
module esc_queue_tracker_chk #(
  parameter int          DEPTH_WIDE   = 6,
  parameter int          DEPTH_NARROW = 4,
  parameter int          ESC_BITS     = 5,
  parameter logic [4:0]  ESC_PATTERN  = 5'b11011,
  parameter int          CW           = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    qstat,
  input logic          fetch_valid,
  input logic          ins_valid,
  input logic          ins_ready,
  input logic [7:0]    ins_op,
  input logic [7:0]    ins_modrm,
  input logic          overrun,
  input logic          wide_q,
  input logic [CW-1:0] cnt_q
);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    wide_q ? (int'(cnt_q) <= DEPTH_WIDE) : (int'(cnt_q) <= DEPTH_NARROW)); // R4

  AST_IDLE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (qstat == 2'b00 && !fetch_valid) |=> $stable(cnt_q)); // R5

  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (qstat == 2'b10) |=> (cnt_q == '0)); // R8

  AST_ESC_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    ins_valid |-> (ins_op[7 -: ESC_BITS] == ESC_PATTERN[ESC_BITS-1:0])); // R6

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && !ins_ready) |=> (ins_valid && $stable(ins_op) && $stable(ins_modrm))); // R9

  AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (qstat == 2'b01 && ins_valid && !ins_ready) |=> overrun); // R10

  AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun); // R10

endmodule

bind esc_queue_tracker esc_queue_tracker_chk #(
  .DEPTH_WIDE(DEPTH_WIDE), .DEPTH_NARROW(DEPTH_NARROW),
  .ESC_BITS(ESC_BITS), .ESC_PATTERN(ESC_PATTERN), .CW(CW)
) i_chk (
  .clk(clk), .rst_n(rst_n), .qstat(qstat), .fetch_valid(fetch_valid),
  .ins_valid(ins_valid), .ins_ready(ins_ready), .ins_op(ins_op),
  .ins_modrm(ins_modrm), .overrun(overrun), .wide_q(wide_q), .cnt_q(cnt_q)
);

// File: tb/test_esc_queue_tracker.sv
`timescale 1ns/1ps
module test_esc_queue_tracker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wide_strap = 1'b1;
  logic        fetch_valid = 1'b0;
  logic [15:0] fetch_data = '0;
  logic [1:0]  qstat = 2'b00;
  logic        ins_valid;
  logic        ins_ready = 1'b1;
  logic [7:0]  ins_op, ins_modrm;
  logic        overrun;

  int n_chk = 0;
  int n_fail = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];
  logic [15:0] mon_e;
  string       mon_t;

  always #2 clk = ~clk;

  esc_queue_tracker i_esc_queue_tracker (
    .clk(clk), .rst_n(rst_n), .wide_strap(wide_strap),
    .fetch_valid(fetch_valid), .fetch_data(fetch_data), .qstat(qstat),
    .ins_valid(ins_valid), .ins_ready(ins_ready), .ins_op(ins_op),
    .ins_modrm(ins_modrm), .overrun(overrun)
  );

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(logic [1:0] qs, logic fv, logic [15:0] d);
    @(posedge clk); #1;
    qstat = qs; fetch_valid = fv; fetch_data = d;
  endtask

  task automatic idle(int n);
    repeat (n) drive(2'b00, 1'b0, 16'h0);
  endtask

  task automatic push(logic [15:0] d);
    drive(2'b00, 1'b1, d);
  endtask

  task automatic pop_pair();
    drive(2'b01, 1'b0, 16'h0);
    drive(2'b11, 1'b0, 16'h0);
  endtask

  task automatic expect_ins(logic [15:0] v, string t);
    exp_q.push_back(v);
    tag_q.push_back(t);
  endtask

  task automatic do_reset(logic strap);
    @(posedge clk); #1;
    rst_n = 1'b0; wide_strap = strap; qstat = 2'b00; fetch_valid = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 valid in reset", {15'h0, ins_valid}, 16'h0);
    chk("R1 overrun in reset", {15'h0, overrun}, 16'h0);
    @(posedge clk); #1;
    rst_n = 1'b1;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && ins_valid && ins_ready) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R7: unexpected instruction actual %h expected none", {ins_op, ins_modrm});
      end else begin
        mon_e = exp_q.pop_front();
        mon_t = tag_q.pop_front();
        if ({ins_op, ins_modrm} !== mon_e) begin
          n_fail++;
          $display("FAIL %s: instruction actual %h expected %h", mon_t, {ins_op, ins_modrm}, mon_e);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R7 watchdog: actual 20000 cycles expected completion earlier");
    summary();
    $finish;
  end

  initial begin
    // R1 reset state, wide host
    do_reset(1'b1);
    @(negedge clk);
    chk("R1 valid after reset", {15'h0, ins_valid}, 16'h0);
    pop_pair();                       // R1/R11 empty queue yields nothing
    idle(2);

    // R2 word fetch, low byte first
    push(16'h3CD9);
    expect_ins(16'hD93C, "R2 byte order");
    pop_pair();
    idle(2);

    // R6 non-escape first bytes are not captured
    push(16'h058B);
    pop_pair();
    push(16'h33D7);
    pop_pair();
    push(16'h11DF);
    expect_ins(16'hDF11, "R6 escape DF");
    pop_pair();
    idle(2);

    // R5 idle codes between the two bytes
    push(16'hC0D8);
    drive(2'b01, 1'b0, 16'h0);
    idle(3);
    expect_ins(16'hD8C0, "R5 idle gap");
    drive(2'b11, 1'b0, 16'h0);
    idle(2);

    // R4 overflow in wide mode
    push(16'h01D8); push(16'h02D9); push(16'h03DA); push(16'h04DB);
    expect_ins(16'hD801, "R4 slot 0");
    expect_ins(16'hD902, "R4 slot 2");
    expect_ins(16'hDA03, "R4 slot 4");
    pop_pair(); pop_pair(); pop_pair();
    pop_pair();                       // R11 empty after six pops
    push(16'h07DD);
    expect_ins(16'hDD07, "R4 after overflow");
    pop_pair();
    idle(2);

    // R8 flush abandons partial capture
    push(16'h55DC);
    drive(2'b01, 1'b0, 16'h0);
    drive(2'b10, 1'b0, 16'h0);
    push(16'hAABB);
    drive(2'b11, 1'b0, 16'h0);
    drive(2'b11, 1'b0, 16'h0);
    drive(2'b10, 1'b1, 16'hE1D8);     // R8 same-cycle fetch dropped
    pop_pair();
    push(16'h0ADA);
    expect_ins(16'hDA0A, "R8 after flush");
    pop_pair();
    idle(2);
    @(negedge clk);
    chk("R10 no overrun yet", {15'h0, overrun}, 16'h0);

    // R9 / R10 hold and overrun
    @(posedge clk); #1; ins_ready = 1'b0;
    push(16'h21D8); push(16'h22D9);
    pop_pair();
    idle(1);
    @(negedge clk);
    chk("R9 valid held", {15'h0, ins_valid}, 16'h1);
    chk("R9 held value", {ins_op, ins_modrm}, 16'hD821);
    idle(3);
    @(negedge clk);
    chk("R9 still held", {ins_op, ins_modrm}, 16'hD821);
    pop_pair();                       // completes while held -> dropped
    idle(1);
    @(negedge clk);
    chk("R10 overrun set", {15'h0, overrun}, 16'h1);
    chk("R10 held unchanged", {ins_op, ins_modrm}, 16'hD821);
    expect_ins(16'hD821, "R9 accepted");
    @(posedge clk); #1; ins_ready = 1'b1;
    idle(2);
    @(negedge clk);
    chk("R9 valid falls", {15'h0, ins_valid}, 16'h0);
    idle(3);
    @(negedge clk);
    chk("R10 sticky", {15'h0, overrun}, 16'h1);

    // R3 narrow host, R12 strap ignored after reset
    do_reset(1'b0);
    @(negedge clk);
    chk("R1 overrun cleared", {15'h0, overrun}, 16'h0);
    wide_strap = 1'b1;
    push(16'hAAD8); push(16'hBB03);
    expect_ins(16'hD803, "R3 R12 byte push");
    pop_pair();
    push(16'hEED9); push(16'hEE01); push(16'hEEDA); push(16'hEE02);
    push(16'hEEDB);                   // R4 narrow overflow ignored
    expect_ins(16'hD901, "R3 narrow slot 0");
    expect_ins(16'hDA02, "R3 narrow slot 2");
    pop_pair(); pop_pair();
    pop_pair();
    push(16'hEEDC); push(16'hEE05);
    expect_ins(16'hDC05, "R4 narrow after overflow");
    pop_pair();
    idle(5);

    chk("R7 scoreboard drained", 16'(exp_q.size()), 16'h0);
    summary();
    $finish;
  end
endmodule